// File: doc/BRIEF.md
# Five-Source Interrupt Latch and Mask Register

This block gathers interrupt requests from five on-chip sources (a synchronous serial port, an asynchronous serial port, two timers and an external pin) and presents one interrupt line to the host processor. Each source gives a one-cycle request pulse. The pulse sets a sticky pending flag for that source. The flag reaches the combined interrupt output only while the source's mask-enable bit is set.

Software reaches the block through a single 16-bit register word. The lower byte holds the per-source enable bits, which can be read and written. The upper byte is write-one-to-clear for the pending flags. When the word is read, the upper byte returns the pending flags instead of anything that was written there. Byte enables let each half be written alone, so an interrupt handler can acknowledge a source without a read-modify-write of the mask.

Top module: `irq_gate_reg`

## Requirements
- R1: After reset, every enable bit and every pending flag is 0, `rdData` reads 0x0000 and `irqOut` is low.
- R2: A write with `byteEn[0]` set loads `wrData[4:0]` into the enable bits, and they read back on `rdData[4:0]`. Bit 0 is the external source, bit 1 timer 1, bit 2 timer 2, bit 3 the asynchronous serial port and bit 4 the synchronous serial port.
- R3: A high `srcReq[i]` at a clock edge sets pending flag i, whatever its enable bit. The flag reads back on `rdData[8+i]` from the next cycle onward and stays set until it is cleared.
- R4: A write with `byteEn[1]` set and `wrData[8+i]`=1 clears pending flag i. A 0 in `wrData[8+i]` leaves that flag unchanged.
- R5: When a request and a clear reach the same source at the same edge, the flag ends up set.
- R6: `irqOut` is high exactly when at least one source has both its pending flag and its enable bit set. A pending flag whose source is disabled does not raise `irqOut`, and it raises `irqOut` once the source is enabled.
- R7: A write with only `byteEn[0]` set leaves the pending flags unchanged, whatever is in `wrData[15:8]`. A write with only `byteEn[1]` set leaves the enable bits unchanged.
- R8: `rdData[7:5]` and `rdData[15:13]` always read 0, including after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| byteEn | input | 2 | Byte lanes of the write: bit 0 = low byte, bit 1 = high byte |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data: pending flags in [12:8], enables in [4:0] |
| srcReq | input | 5 | One request pulse per source, same bit order as the enables |
| irqOut | output | 1 | Combined interrupt to the host |

## Verification
The hardest case to reach from the ports is a request and a clear landing on the same flag in the same cycle. The bench drives a single cycle that carries both a high-byte clear write and the matching `srcReq` pulse, then reads the word back to confirm the flag survived. A neighbouring flag is cleared in that same cycle, which shows the clear path was live. Byte-lane isolation is checked with writes whose unused byte holds all ones, so any leak through that lane would change the readback.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int NUM_SRC  = 5;
  localparam int REG_W    = 16;
  localparam int LANE_W   = 8;
  localparam int CLR_BASE = LANE_W;

  typedef struct packed {
    logic               enWr;
    logic [NUM_SRC-1:0] enData;
    logic [NUM_SRC-1:0] clrMask;
  } strobe_t;
endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
(
  input  logic             wrEn,
  input  logic [1:0]       byteEn,
  input  logic [REG_W-1:0] wrData,
  output strobe_t          strobe
);
  logic loLane;
  logic hiLane;

  always_comb begin
    loLane         = wrEn & byteEn[0];
    hiLane         = wrEn & byteEn[1];
    strobe.enWr    = loLane;
    strobe.enData  = wrData[NUM_SRC-1:0];
    strobe.clrMask = hiLane ? wrData[CLR_BASE +: NUM_SRC] : '0;
  end
endmodule

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic [NUM_SRC-1:0] enable,
  output logic [NUM_SRC-1:0] pending
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= '0;
    end else if (strobe.enWr) begin
      enable <= strobe.enData;
    end
  end

  // A request outranks a clear that targets the same flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      pending <= (pending & ~strobe.clrMask) | srcReq;
    end
  end

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq != '0) |=> ((pending & $past(srcReq)) == $past(srcReq))); // R3

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.clrMask & ~srcReq) != '0) |=>
      ((pending & $past(strobe.clrMask & ~srcReq)) == '0)); // R4

  AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.clrMask & srcReq) != '0) |=>
      ((pending & $past(strobe.clrMask & srcReq)) == $past(strobe.clrMask & srcReq))); // R5

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enWr |=> $stable(enable)); // R7

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.clrMask == '0) && (srcReq == '0)) |=> $stable(pending)); // R7
endmodule

// File: rtl/irq_gate_reg.sv
module irq_gate_reg
  import irq_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        byteEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic              irqOut
);
  strobe_t            strobe;
  logic [NUM_SRC-1:0] enable;
  logic [NUM_SRC-1:0] pending;

  irq_gate_ctrl i_ctrl (
    .wrEn   (wrEn),
    .byteEn (byteEn),
    .wrData (wrData),
    .strobe (strobe)
  );

  irq_gate_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcReq  (srcReq),
    .enable  (enable),
    .pending (pending)
  );

  always_comb begin
    rdData                         = '0;
    rdData[NUM_SRC-1:0]            = enable;
    rdData[CLR_BASE +: NUM_SRC]    = pending;
    irqOut                         = |(pending & enable);
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ((rdData[CLR_BASE +: NUM_SRC] & rdData[NUM_SRC-1:0]) != '0)); // R6

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[LANE_W-1:NUM_SRC] == '0) && (rdData[REG_W-1:CLR_BASE+NUM_SRC] == '0)); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> (rdData == '0) && !irqOut); // R1
endmodule

// File: tb/test_irq_gate_reg.sv
module test_irq_gate_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  byteEn = 2'b00;
  logic [15:0] wrData = 16'h0000;
  logic [15:0] rdData;
  logic [4:0]  srcReq = 5'b0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_gate_reg i_irq_gate_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .srcReq(srcReq), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock cycle of stimulus, applied at a falling edge; results are sampled at the next falling edge.
  task automatic cycle(input logic we, input logic [1:0] be, input logic [15:0] d, input logic [4:0] rq);
    @(negedge clk);
    wrEn = we; byteEn = be; wrData = d; srcReq = rq;
    @(negedge clk);
    wrEn = 1'b0; byteEn = 2'b00; wrData = 16'h0000; srcReq = 5'b0;
  endtask

  task automatic t_reset();
    check("R1 rdData", rdData, 16'h0000);
    check("R1 irqOut", {15'b0, irqOut}, 16'h0000);
  endtask

  task automatic t_enable();
    cycle(1'b1, 2'b01, 16'h001F, 5'b0);
    check("R2 all enables", rdData, 16'h001F);
    cycle(1'b1, 2'b01, 16'h0005, 5'b0);
    check("R2 partial enables", rdData, 16'h0005);
    check("R6 no pending no irq", {15'b0, irqOut}, 16'h0000);
    cycle(1'b1, 2'b01, 16'h0000, 5'b0);
  endtask

  task automatic t_latch_gate();
    cycle(1'b0, 2'b00, 16'h0000, 5'b10010);
    check("R3 pending latched", rdData, 16'h1200);
    check("R6 disabled not forwarded", {15'b0, irqOut}, 16'h0000);
    cycle(1'b0, 2'b00, 16'h0000, 5'b0);
    check("R3 pending sticky", rdData, 16'h1200);
    cycle(1'b1, 2'b01, 16'h0002, 5'b0);
    check("R6 enabled forwards", {15'b0, irqOut}, 16'h0001);
    cycle(1'b1, 2'b01, 16'h0001, 5'b0);
    check("R6 other enable only", {15'b0, irqOut}, 16'h0000);
  endtask

  task automatic t_clear();
    cycle(1'b1, 2'b10, 16'h1000, 5'b0);
    check("R4 clear bit 12 only", rdData, 16'h0201);
    cycle(1'b1, 2'b10, 16'h0200, 5'b0);
    check("R4 clear bit 9", rdData, 16'h0001);
    check("R4 irq gone", {15'b0, irqOut}, 16'h0000);
  endtask

  task automatic t_race();
    cycle(1'b0, 2'b00, 16'h0000, 5'b00101);
    check("R3 two flags", rdData, 16'h0501);
    check("R6 bit0 enabled pending", {15'b0, irqOut}, 16'h0001);
    cycle(1'b1, 2'b10, 16'h0500, 5'b00001);
    check("R5 request beats clear", rdData, 16'h0101);
    cycle(1'b1, 2'b10, 16'h0100, 5'b0);
    check("R4 cleared after race", rdData, 16'h0001);
  endtask

  task automatic t_lanes();
    cycle(1'b0, 2'b00, 16'h0000, 5'b11000);
    cycle(1'b1, 2'b01, 16'hFF1F, 5'b0);
    check("R7 low lane keeps pending", rdData, 16'h181F);
    cycle(1'b1, 2'b10, 16'h0800, 5'b0);
    check("R7 high lane keeps enables", rdData, 16'h101F);
    cycle(1'b1, 2'b10, 16'h1000, 5'b0);
    check("R7 high lane clear, enables kept", rdData, 16'h001F);
    cycle(1'b1, 2'b00, 16'hFFFF, 5'b0);
    check("R7 no lane no change", rdData, 16'h001F);
  endtask

  task automatic t_pads();
    cycle(1'b0, 2'b00, 16'h0000, 5'b11111);
    cycle(1'b1, 2'b01, 16'hFFFF, 5'b0);
    check("R8 pad bits zero", rdData & 16'hE0E0, 16'h0000);
    check("R8 full readback", rdData, 16'h1F1F);
    cycle(1'b1, 2'b11, 16'hFFFF, 5'b0);
    check("R8 after full write", rdData, 16'h001F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_enable();
    t_latch_gate();
    t_clear();
    t_race();
    t_lanes();
    t_pads();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule